// File: doc/BRIEF.md
# Random-Side Access Decoder for a Shared Buffer Memory

This block sits on the random-access side of a buffer memory that a streaming engine shares on its other port. On each clock edge it samples a set of active-low strobes: chip select, command select, read/write, output enable and a lower and an upper byte enable. The chip select opens the word-wide data array. The command select opens a small bank of eight command slots, which hold the start and end addresses of two buffers, a flag word and a control word. It never touches both.

The array is kept outside the block. The block drives the address, the write data and per-byte write strobes, and it pulses a read request. The array returns its word one cycle later, and the block merges it with register read data into one registered read path that has a valid flag. End-of-buffer events from the streaming side set two sticky flags. Software clears a flag by writing a zero into the matching bit of the control word. The two buffers' addresses and both flags are offered as outputs for the streaming side.

Top module: `rpd_port`

## Requirements
- R1: With chip select low and command select high, a low read/write writes the array at `addr` through `arr_we`, and a high read/write reads the array word at `addr`.
- R2: With command select low, `addr[2:0]` picks a command slot and data bits 11:0 carry its value. Slot 0 is buffer 1 start, 1 is buffer 1 end, 2 is buffer 2 start, 3 is buffer 2 end, 4 is the flag word (bit 0 is buffer 1, bit 1 is buffer 2) and 5 is the control word. Slots 6 and 7 read as zero. Writes to slots 4, 6 and 7 change nothing. Writes ignore data bits 15:12, and reads return the 12-bit value zero-extended to 16 bits.
- R3: When chip select and command select are both low, `sel_clash` is high in that cycle. No array write or register write takes place, and `rd_valid` stays low in the next cycle.
- R4: The lower byte enable gates bits 7:0 and the upper byte enable gates bits 15:8, each on its own. This holds for array writes, for register writes (bits 11:8 on the upper lane) and for reads. A disabled lane reads as zero.
- R5: `rd_valid` is high in the cycle after a read (read/write high) with output enable low, and then `rdata` carries that word. Otherwise `rd_valid` is low and `rdata` is zero.
- R6: A control-word write with the lower lane enabled clears flag 0 if data bit 0 is zero, and clears flag 1 if data bit 1 is zero. A one in either bit leaves that flag as it was.
- R7: A high `eob_hit[i]` sets flag i at the next edge, even when a clear of that flag happens in the same cycle.
- R8: With both selects high, the port is idle. It drives no array strobe, no register changes, and `rd_valid` is low in the next cycle.
- R9: After reset, every command slot and both flags are zero and `rd_valid` is low.
- R10: `buf1_start`, `buf1_end`, `buf2_start` and `buf2_end` show the contents of slots 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Array select, active low |
| cmd_n | input | 1 | Command slot select, active low |
| rw_n | input | 1 | High reads, low writes |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| addr | input | ADDR_W | Word address; low 3 bits pick a command slot |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, lane-masked |
| rd_valid | output | 1 | Read data valid |
| sel_clash | output | 1 | Both selects low in this cycle |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_we | output | DATA_W/8 | Array byte write strobes |
| arr_re | output | 1 | Array read request |
| arr_rdata | input | DATA_W | Array read word, one cycle after `arr_re` |
| eob_hit | input | 2 | End-of-buffer events from the streaming side |
| eob_flag | output | 2 | Sticky end-of-buffer flags |
| buf1_start | output | REG_W | Buffer 1 start address |
| buf1_end | output | REG_W | Buffer 1 end address |
| buf2_start | output | REG_W | Buffer 2 start address |
| buf2_end | output | REG_W | Buffer 2 end address |

## Verification
The bench builds the block with its defaults: a 13-bit address, a 16-bit word and 12-bit command slots. That puts the top array word 0x1FFF and the upper nibble of each slot (bits 11:8, on the upper lane) within reach. It also lets the bench show that data bits 15:12 are dropped on register writes and read back as zero. Because the word holds exactly two lanes, every combination of the lower and upper enables can be tried on the array, on the slots and on the control-word clear.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_ARRAY = 2'd1,
    ACC_CMD   = 2'd2,
    ACC_CLASH = 2'd3
  } acc_kind_e;

  localparam int unsigned NUM_BUF  = 2;
  localparam int unsigned CA_FLAGS = 4;
  localparam int unsigned CA_CTRL  = 5;
endpackage

// File: rtl/rpd_rst_sync.sv
module rpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rpd_decode.sv
module rpd_decode
  import rpd_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cmd_n,
  input  logic             rw_n,
  input  logic             oe_n,
  input  logic             lb_n,
  input  logic             ub_n,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] arr_we,
  output logic             arr_re,
  output logic             reg_we,
  output logic             rd_accept,
  output logic             src_is_reg,
  output logic             clash
);
  acc_kind_e kind;

  always_comb begin
    unique case ({ce_n, cmd_n})
      2'b01:   kind = ACC_ARRAY;
      2'b10:   kind = ACC_CMD;
      2'b00:   kind = ACC_CLASH;
      default: kind = ACC_IDLE;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l < LANES / 2) begin : g_lo
      assign lane_en[l] = !lb_n;
    end else begin : g_hi
      assign lane_en[l] = !ub_n;
    end
  end

  always_comb begin
    arr_we     = (kind == ACC_ARRAY && !rw_n) ? lane_en : '0;
    arr_re     = (kind == ACC_ARRAY) && rw_n;
    reg_we     = (kind == ACC_CMD) && !rw_n;
    rd_accept  = (kind == ACC_ARRAY || kind == ACC_CMD) && rw_n && !oe_n;
    src_is_reg = (kind == ACC_CMD);
    clash      = (kind == ACC_CLASH);
  end

  // lane strobes only follow their own enable pins
  assert_lane_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we[0] |-> !lb_n) and (arr_we[LANES-1] |-> !ub_n));

  // an array read request only arises from an array-selected read
  assert_array_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arr_re |-> (!ce_n && cmd_n && rw_n));
endmodule

// File: rtl/rpd_cmd_regs.sv
module rpd_cmd_regs
  import rpd_pkg::*;
#(
  parameter int REG_W  = 12,
  parameter int CMD_AW = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [CMD_AW-1:0]               reg_addr,
  input  logic [REG_W-1:0]                wdata,
  input  logic [REG_W-1:0]                wmask,
  input  logic [NUM_BUF-1:0]              eob_hit,
  output logic [REG_W-1:0]                rd_val,
  output logic [NUM_BUF-1:0][REG_W-1:0]   start_q,
  output logic [NUM_BUF-1:0][REG_W-1:0]   end_q,
  output logic [NUM_BUF-1:0]              eob_flag
);
  logic             ctrl_sel;
  logic             ctrl_wr;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] ctrl_d;

  assign ctrl_sel = (reg_addr == CMD_AW'(CA_CTRL));
  assign ctrl_wr  = reg_we && ctrl_sel;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic             wr_start;
    logic             wr_end;
    logic [REG_W-1:0] start_r;
    logic [REG_W-1:0] end_r;
    logic [REG_W-1:0] start_d;
    logic [REG_W-1:0] end_d;
    logic             clr;
    logic             flag_r;
    logic             flag_d;

    assign wr_start = reg_we && (reg_addr == CMD_AW'(2 * i));
    assign wr_end   = reg_we && (reg_addr == CMD_AW'(2 * i + 1));
    assign clr      = ctrl_wr && wmask[i] && !wdata[i];

    always_comb begin
      start_d = (start_r & ~wmask) | (wdata & wmask);
      end_d   = (end_r & ~wmask) | (wdata & wmask);
      flag_d  = eob_hit[i] | (flag_r & !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_r <= '0;
      end else if (wr_start) begin
        start_r <= start_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        end_r <= '0;
      end else if (wr_end) begin
        end_r <= end_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_r <= 1'b0;
      else        flag_r <= flag_d;
    end

    assign start_q[i]  = start_r;
    assign end_q[i]    = end_r;
    assign eob_flag[i] = flag_r;

    // a software clear without a coinciding event drops the flag
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !eob_hit[i]) |=> !eob_flag[i]);

    // an event always leaves the flag set, clear or not
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eob_hit[i] |=> eob_flag[i]);
  end

  always_comb begin
    ctrl_d = (ctrl_q & ~wmask) | (wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (reg_addr == CMD_AW'(2 * i))     rd_val = start_q[i];
      if (reg_addr == CMD_AW'(2 * i + 1)) rd_val = end_q[i];
    end
    if (reg_addr == CMD_AW'(CA_FLAGS)) rd_val = REG_W'(eob_flag);
    if (ctrl_sel)                      rd_val = ctrl_q;
  end

  // writes to the flag slot or the unused slots leave every stored word alone
  assert_ro_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr >= CMD_AW'(CA_FLAGS) && !ctrl_sel)
      |=> ($stable(start_q) && $stable(end_q) && $stable(ctrl_q)));
endmodule

// File: rtl/rpd_rdmux.sv
module rpd_rdmux #(
  parameter int DATA_W = 16,
  parameter int REG_W  = 12,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_accept,
  input  logic              src_is_reg,
  input  logic [LANES-1:0]  lane_en,
  input  logic [REG_W-1:0]  reg_val,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  logic              valid_q;
  logic              valid_d;
  logic              src_q;
  logic [LANES-1:0]  lane_q;
  logic [REG_W-1:0]  regval_q;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] raw;

  assign valid_d = rd_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= 1'b0;
      lane_q   <= '0;
      regval_q <= '0;
    end else if (rd_accept) begin
      src_q    <= src_is_reg;
      lane_q   <= lane_en;
      regval_q <= reg_val;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[l*8 +: 8] = {8{lane_q[l]}};
  end

  always_comb begin
    raw      = src_q ? DATA_W'(regval_q) : arr_rdata;
    rdata    = valid_q ? (raw & lane_mask) : '0;
    rd_valid = valid_q;
  end

  // valid read data only ever follows an accepted read
  assert_valid_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_accept));

  assert_accept_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> rd_valid);
endmodule

// File: rtl/rpd_port.sv
module rpd_port
  import rpd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int REG_W  = 12,
  parameter int CMD_AW = 3,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cmd_n,
  input  logic              rw_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              sel_clash,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [LANES-1:0]  arr_we,
  output logic              arr_re,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [1:0]        eob_hit,
  output logic [1:0]        eob_flag,
  output logic [REG_W-1:0]  buf1_start,
  output logic [REG_W-1:0]  buf1_end,
  output logic [REG_W-1:0]  buf2_start,
  output logic [REG_W-1:0]  buf2_end
);
  logic                          rst_n_s;
  logic [LANES-1:0]              lane_en;
  logic                          reg_we;
  logic                          rd_accept;
  logic                          src_is_reg;
  logic [REG_W-1:0]              wmask;
  logic [REG_W-1:0]              reg_val;
  logic [NUM_BUF-1:0][REG_W-1:0] start_q;
  logic [NUM_BUF-1:0][REG_W-1:0] end_q;

  rpd_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rpd_decode #(.DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ce_n       (ce_n),
    .cmd_n      (cmd_n),
    .rw_n       (rw_n),
    .oe_n       (oe_n),
    .lb_n       (lb_n),
    .ub_n       (ub_n),
    .lane_en    (lane_en),
    .arr_we     (arr_we),
    .arr_re     (arr_re),
    .reg_we     (reg_we),
    .rd_accept  (rd_accept),
    .src_is_reg (src_is_reg),
    .clash      (sel_clash)
  );

  for (genvar b = 0; b < REG_W; b++) begin : g_wmask
    assign wmask[b] = lane_en[b / 8];
  end

  rpd_cmd_regs #(.REG_W(REG_W), .CMD_AW(CMD_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .reg_we   (reg_we),
    .reg_addr (addr[CMD_AW-1:0]),
    .wdata    (wdata[REG_W-1:0]),
    .wmask    (wmask),
    .eob_hit  (eob_hit),
    .rd_val   (reg_val),
    .start_q  (start_q),
    .end_q    (end_q),
    .eob_flag (eob_flag)
  );

  rpd_rdmux #(.DATA_W(DATA_W), .REG_W(REG_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rd_accept  (rd_accept),
    .src_is_reg (src_is_reg),
    .lane_en    (lane_en),
    .reg_val    (reg_val),
    .arr_rdata  (arr_rdata),
    .rdata      (rdata),
    .rd_valid   (rd_valid)
  );

  assign arr_addr   = addr;
  assign arr_wdata  = wdata;
  assign buf1_start = start_q[0];
  assign buf1_end   = end_q[0];
  assign buf2_start = start_q[1];
  assign buf2_end   = end_q[1];

  // both selects low: flagged, and nothing is written or read
  assert_clash_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ce_n && !cmd_n) |-> (sel_clash && arr_we == '0 && !reg_we && !rd_accept));

  // both selects high: the port stays quiet
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ce_n && cmd_n) |-> (arr_we == '0 && !arr_re && !reg_we && !rd_accept));
endmodule

// File: tb/rpd_port_test.sv
module rpd_port_test;
  localparam int CYC = 20;

  logic        clk;
  logic        rst_n;
  logic        ce_n, cmd_n, rw_n, oe_n, lb_n, ub_n;
  logic [12:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rd_valid;
  logic        sel_clash;
  logic [12:0] arr_addr;
  logic [15:0] arr_wdata;
  logic [1:0]  arr_we;
  logic        arr_re;
  logic [15:0] arr_rdata;
  logic [1:0]  eob_hit;
  logic [1:0]  eob_flag;
  logic [11:0] buf1_start, buf1_end, buf2_start, buf2_end;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          v;
    logic [15:0] d;
    string       req;
  } exp_t;
  exp_t q[$];

  logic [15:0] mem_model[int];
  logic [15:0] exp_mem[int];
  logic [11:0] sh_reg[8];
  logic [1:0]  sh_flag;

  rpd_port uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_n(cmd_n), .rw_n(rw_n),
    .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .sel_clash(sel_clash),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we),
    .arr_re(arr_re), .arr_rdata(arr_rdata), .eob_hit(eob_hit),
    .eob_flag(eob_flag), .buf1_start(buf1_start), .buf1_end(buf1_end),
    .buf2_start(buf2_start), .buf2_end(buf2_end)
  );

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  // array model: synchronous read, byte-strobed write
  always @(posedge clk) begin
    logic [15:0] cur;
    cur = mem_model.exists(int'(arr_addr)) ? mem_model[int'(arr_addr)] : 16'h0000;
    if (arr_re) arr_rdata <= cur;
    if (arr_we[0]) cur[7:0]  = arr_wdata[7:0];
    if (arr_we[1]) cur[15:8] = arr_wdata[15:8];
    if (|arr_we) mem_model[int'(arr_addr)] = cur;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: one expectation per driven cycle
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check({it.req, " rd_valid"}, 32'(rd_valid), 32'(it.v));
      check({it.req, " rdata"}, 32'(rdata), it.v ? 32'(it.d) : 32'h0);
    end
  end

  task automatic cyc(input bit ce, input bit cmd, input bit rw, input bit oe,
                     input bit lb, input bit ub, input logic [12:0] a,
                     input logic [15:0] d, input logic [1:0] hit,
                     input bit ev, input logic [15:0] ed, input string req);
    exp_t it;
    @(negedge clk);
    ce_n = ce; cmd_n = cmd; rw_n = rw; oe_n = oe; lb_n = lb; ub_n = ub;
    addr = a; wdata = d; eob_hit = hit;
    it.v = ev; it.d = ed; it.req = req;
    q.push_back(it);
  endtask

  function automatic logic [15:0] lmask(input bit lo, input bit hi);
    return {hi ? 8'hFF : 8'h00, lo ? 8'hFF : 8'h00};
  endfunction

  task automatic idle(input logic [1:0] hit);
    cyc(1, 1, 1, 1, 0, 0, 13'h0, 16'h0, hit, 0, 16'h0, "R8");
    sh_flag = sh_flag | hit;
  endtask

  task automatic aw(input logic [12:0] a, input logic [15:0] d, input bit lo, input bit hi);
    logic [15:0] cur;
    cyc(0, 1, 0, 1, !lo, !hi, a, d, 2'b00, 0, 16'h0, "R1");
    cur = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0;
    cur = (cur & ~lmask(lo, hi)) | (d & lmask(lo, hi));
    exp_mem[int'(a)] = cur;
  endtask

  task automatic ar(input logic [12:0] a, input bit lo, input bit hi, input bit oe_en, input string req);
    logic [15:0] cur;
    cur = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0;
    cyc(0, 1, 1, !oe_en, !lo, !hi, a, 16'h0, 2'b00, oe_en, cur & lmask(lo, hi), req);
  endtask

  task automatic cw(input logic [2:0] ra, input logic [15:0] d, input bit lo, input bit hi,
                    input logic [1:0] hit, input string req);
    logic [11:0] m;
    logic [1:0]  clr;
    m = lmask(lo, hi)[11:0];
    cyc(1, 0, 0, 1, !lo, !hi, {10'h0, ra}, d, hit, 0, 16'h0, req);
    if (ra < 4 || ra == 5) sh_reg[ra] = (sh_reg[ra] & ~m) | (d[11:0] & m);
    clr = (ra == 5) ? {lo && !d[1], lo && !d[0]} : 2'b00;
    sh_flag = (sh_flag & ~clr) | hit;
  endtask

  task automatic cr(input logic [2:0] ra, input bit lo, input bit hi, input string req);
    logic [11:0] v;
    if (ra == 4)     v = {10'h0, sh_flag};
    else if (ra > 5) v = 12'h0;
    else             v = sh_reg[ra];
    cyc(1, 0, 1, 0, !lo, !hi, {10'h0, ra}, 16'h0, 2'b00, 1, {4'h0, v} & lmask(lo, hi), req);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CYC * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; ce_n = 1; cmd_n = 1; rw_n = 1; oe_n = 1; lb_n = 0; ub_n = 0;
    addr = '0; wdata = '0; eob_hit = '0; arr_rdata = '0;
    sh_flag = '0;
    for (int i = 0; i < 8; i++) sh_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 / R10: reset state
    check("R9 rd_valid", 32'(rd_valid), 0);
    check("R9 rdata", 32'(rdata), 0);
    check("R9 eob_flag", 32'(eob_flag), 0);
    check("R10 buf1_start", 32'(buf1_start), 0);
    check("R10 buf2_end", 32'(buf2_end), 0);

    // R1: array write and read
    aw(13'h0010, 16'hA55A, 1, 1);
    ar(13'h0010, 1, 1, 1, "R1");
    aw(13'h1FFF, 16'h1234, 1, 1);
    ar(13'h1FFF, 1, 1, 1, "R1 top address");

    // R4: byte lanes on the array
    aw(13'h0010, 16'hFFFF, 1, 0);
    aw(13'h0010, 16'h3C00, 0, 1);
    ar(13'h0010, 1, 1, 1, "R4 merged");
    ar(13'h0010, 1, 0, 1, "R4 lower only");
    ar(13'h0010, 0, 1, 1, "R4 upper only");

    // R5: output enable high gives no valid data
    ar(13'h0010, 1, 1, 0, "R5 oe high");
    cyc(1, 0, 1, 1, 0, 0, 13'h1, 16'h0, 2'b00, 0, 16'h0, "R5 reg oe high");

    // R2 / R10: command slots
    cw(3'd0, 16'h0123, 1, 1, 2'b00, "R2");
    cw(3'd1, 16'h0ABC, 1, 1, 2'b00, "R2");
    cw(3'd2, 16'h07FF, 1, 1, 2'b00, "R2");
    cw(3'd3, 16'h0FFF, 1, 1, 2'b00, "R2");
    idle(2'b00);
    check("R10 buf1_start", 32'(buf1_start), 32'h123);
    check("R10 buf1_end", 32'(buf1_end), 32'hABC);
    check("R10 buf2_start", 32'(buf2_start), 32'h7FF);
    check("R10 buf2_end", 32'(buf2_end), 32'hFFF);
    cr(3'd1, 1, 1, "R2 readback");
    cw(3'd0, 16'hF456, 1, 1, 2'b00, "R2 high bits dropped");
    cr(3'd0, 1, 1, "R2 high bits dropped");
    cw(3'd2, 16'h00A5, 1, 0, 2'b00, "R4 reg lower lane");
    cr(3'd2, 1, 1, "R4 reg lower lane");
    cr(3'd3, 0, 1, "R4 reg upper read");
    cw(3'd6, 16'h0FFF, 1, 1, 2'b00, "R2 slot 6");
    cw(3'd7, 16'h0FFF, 1, 1, 2'b00, "R2 slot 7");
    cw(3'd4, 16'h0FFF, 1, 1, 2'b00, "R2 slot 4");
    cr(3'd6, 1, 1, "R2 slot 6 zero");
    cr(3'd7, 1, 1, "R2 slot 7 zero");
    cr(3'd4, 1, 1, "R2 flags untouched");
    check("R2 buf2_start kept", 32'(buf2_start), 32'h7A5);

    // R7: events set flags
    idle(2'b01);
    idle(2'b00);
    check("R7 flag0 set", 32'(eob_flag), 32'h1);
    cr(3'd4, 1, 1, "R7 flag word");
    idle(2'b10);
    cr(3'd4, 1, 1, "R7 both flags");

    // R6: clear through the control word
    cw(3'd5, 16'h0002, 1, 1, 2'b00, "R6 clear flag0");
    idle(2'b00);
    check("R6 flag0 cleared", 32'(eob_flag), 32'h2);
    cr(3'd5, 1, 1, "R6 control readback");
    cw(3'd5, 16'h0000, 0, 1, 2'b00, "R6 lower lane off");
    idle(2'b00);
    check("R6 no clear without lower lane", 32'(eob_flag), 32'h2);
    cw(3'd5, 16'h0000, 1, 1, 2'b10, "R7 set beats clear");
    idle(2'b00);
    check("R7 set beats clear", 32'(eob_flag), 32'h2);
    cw(3'd5, 16'h0001, 1, 1, 2'b00, "R6 clear flag1");
    idle(2'b00);
    check("R6 flag1 cleared", 32'(eob_flag), 32'h0);

    // R3: both selects low
    cyc(0, 0, 0, 1, 0, 0, 13'h0010, 16'hDEAD, 2'b00, 0, 16'h0, "R3 write");
    #1;
    check("R3 sel_clash", 32'(sel_clash), 1);
    check("R3 arr_we", 32'(arr_we), 0);
    cyc(0, 0, 1, 0, 0, 0, 13'h0000, 16'h0, 2'b00, 0, 16'h0, "R3 read");
    ar(13'h0010, 1, 1, 1, "R3 array kept");
    cr(3'd0, 1, 1, "R3 slot kept");

    // R8: idle with write-looking inputs
    cyc(1, 1, 0, 0, 0, 0, 13'h0010, 16'hBEEF, 2'b00, 0, 16'h0, "R8 idle");
    #1;
    check("R8 arr_we", 32'(arr_we), 0);
    check("R8 arr_re", 32'(arr_re), 0);
    check("R8 sel_clash", 32'(sel_clash), 0);
    ar(13'h0010, 1, 1, 1, "R8 array kept");
    cr(3'd1, 1, 1, "R8 slot kept");

    repeat (3) idle(2'b00);
    @(negedge clk);
    check("scoreboard drained", 32'(q.size()), 0);
    summary();
  end
endmodule